// File: doc/BRIEF.md
# Snooping Bus Intervention Controller

This block sits between four private caches and a shared main memory. It owns the single shared bus. It decides which cache may run the next transaction. It announces each transaction to every cache so that each one can snoop it. It then finishes the transaction in one of three ways:

- It fetches the line from memory.
- It cancels the memory fetch and lets a snooping cache supply the line.
- For an invalidate, it only gathers the responses.

When a cache supplies a line it held modified, the controller also writes the supplied word back into memory. The next memory fetch of that address then sees the new value.

Each cache raises its request with a kind (read or invalidate) and an address. It holds the request until the controller returns a response. During the snoop cycle, every cache presents two flags: whether it holds the line, and whether its copy is modified. The cache picked as supplier puts its word on its data lane in the cycle it is selected. Memory is a block-RAM-style internal array. Its contents at power-up are a fixed function of the address.

Top module: `snoop_bus_ctrl`

## Requirements
- R1: At most one bit of `grant` is high at any time.
- R2: Arbitration is round-robin. When idle, the controller raises the grant one cycle after it sees requests. Search starts at the index after the last owner; after reset it starts at index 0.
- R3: `grant` holds steady for the whole transaction. It is still high in the cycle `rsp_valid` is high, and it is low in the cycle after.
- R4: In the first cycle of each grant, `snp_valid` is high for exactly one cycle. `snp_addr`, `snp_inv` and `snp_src` carry the owner's address, its kind (1 = invalidate) and its index.
- R5: A read that no other cache holds returns the memory word. `rsp_valid` rises MEM_LAT+1 cycles after the grant rises.
- R6: For a read that another cache holds, the memory fetch is cancelled. `sup_sel` is one-hot for one cycle, right after the snoop cycle, and picks the lowest-numbered responding non-requester. `rsp_data` is that cache's lane, and `rsp_valid` follows in the next cycle.
- R7: The requester's own `snp_hit` and `snp_dirty` have no effect on the outcome.
- R8: `rsp_shared` is 1 exactly when some cache other than the requester reported `snp_hit`. This holds for both reads and invalidates.
- R9: When the chosen supplier reported `snp_dirty`, its word is written into memory at the transaction address.
- R10: A cancelled fetch from a clean supplier leaves memory at that address unchanged.
- R11: An invalidate selects no supplier and returns `rsp_data` = 0. Its `rsp_valid` is high in the cycle after the snoop cycle.
- R12: At power-up, memory word `a` holds `(a * 0x9E3779B1) ^ 0xA5A50000`, truncated to DATA_W.
- R13: During and after reset, with no requests, `grant`, `sup_sel`, `snp_valid` and `rsp_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_CACHE | Per-cache request, held until its response |
| req_inv | input | N_CACHE | Per-cache kind: 1 invalidate, 0 read |
| req_addr | input | N_CACHE*ADDR_W | Per-cache word address, cache k in slice k |
| grant | output | N_CACHE | One-hot bus ownership |
| snp_valid | output | 1 | Snoop broadcast strobe |
| snp_inv | output | 1 | Broadcast kind |
| snp_addr | output | ADDR_W | Broadcast address |
| snp_src | output | $clog2(N_CACHE) | Index of the owning cache |
| snp_hit | input | N_CACHE | Snoop response: cache holds the line |
| snp_dirty | input | N_CACHE | Snoop response: cache copy is modified |
| sup_sel | output | N_CACHE | One-hot supplier select |
| sup_data | input | N_CACHE*DATA_W | Per-cache supply lanes |
| rsp_valid | output | 1 | Response strobe to the owner |
| rsp_data | output | DATA_W | Response word |
| rsp_shared | output | 1 | Some other cache holds the line |

## Verification
Reads are tried with four response patterns:

- No holder at all, which exercises the memory path and its latency.
- Only the requester holding the line, which shows its own response is ignored.
- Two clean holders, which shows the lowest-index pick and that memory stays unchanged.
- A modified holder beside a higher clean one, where a later plain read tells write-back from no write-back.

Invalidates are run with and without other holders; this separates the shared flag from the supplier path. Three caches request at once, and the bench compares the resulting grant order with the rotating-priority rule across several rounds.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SNOOP,
    ST_SUPPLY,
    ST_MEMRD,
    ST_DONE
  } bus_state_t;

  function automatic logic [31:0] power_up_word(input int unsigned a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hA5A50000;
  endfunction

endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N     = 4,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic [N-1:0]  pick_oh,
  output logic [IW-1:0] pick_idx,
  output logic          pick_any
);
  // Walk offsets from farthest to nearest so the nearest requester wins.
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      automatic int j = (int'(start) + k) % N;
      if (req[j]) begin
        pick_oh    = '0;
        pick_oh[j] = 1'b1;
        pick_idx   = IW'(j);
        pick_any   = 1'b1;
      end
    end
  end

  // R1
  pick_onehot_chk: assert final ($onehot0(pick_oh));
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  oh,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    oh  = '0;
    idx = '0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[k]) begin
        oh    = '0;
        oh[k] = 1'b1;
        idx   = IW'(k);
        any   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/snoop_mem.sv
module snoop_mem
  import snoop_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  // R12: fixed power-up pattern
  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = DW'(power_up_word(i));
  end

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/snoop_bus_ctrl.sv
module snoop_bus_ctrl
  import snoop_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int MEM_LAT = 3,
  localparam int IDX_W  = (N_CACHE > 1) ? $clog2(N_CACHE) : 1,
  localparam int CNT_W  = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_CACHE-1:0]          req_valid,
  input  logic [N_CACHE-1:0]          req_inv,
  input  logic [N_CACHE*ADDR_W-1:0]   req_addr,
  output logic [N_CACHE-1:0]          grant,
  output logic                        snp_valid,
  output logic                        snp_inv,
  output logic [ADDR_W-1:0]           snp_addr,
  output logic [IDX_W-1:0]            snp_src,
  input  logic [N_CACHE-1:0]          snp_hit,
  input  logic [N_CACHE-1:0]          snp_dirty,
  output logic [N_CACHE-1:0]          sup_sel,
  input  logic [N_CACHE*DATA_W-1:0]   sup_data,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  output logic                        rsp_shared
);
  bus_state_t         state;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   sup_idx;
  logic               sup_dirty_q;
  logic [CNT_W-1:0]   wait_cnt;

  // arbitration
  logic [N_CACHE-1:0] arb_oh;
  logic [IDX_W-1:0]   arb_idx;
  logic               arb_any;

  rr_arbiter #(.N(N_CACHE)) u_arb (
    .req      (req_valid),
    .start    (rr_ptr),
    .pick_oh  (arb_oh),
    .pick_idx (arb_idx),
    .pick_any (arb_any)
  );

  // supplier choice: other caches only, lowest index first
  logic [N_CACHE-1:0] other_hit;
  logic [N_CACHE-1:0] pick_oh;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;

  assign other_hit = snp_hit & ~grant;

  lowest_pick #(.N(N_CACHE)) u_pick (
    .vec (other_hit),
    .oh  (pick_oh),
    .idx (pick_idx),
    .any (pick_any)
  );

  // memory
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] sup_word;
  logic              mem_we;

  assign sup_word = sup_data[sup_idx*DATA_W +: DATA_W];
  assign mem_we   = (state == ST_SUPPLY) && sup_dirty_q;

  snoop_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (snp_addr),
    .wdata (sup_word),
    .raddr (snp_addr),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rr_ptr      <= '0;
      grant       <= '0;
      snp_valid   <= 1'b0;
      snp_inv     <= 1'b0;
      snp_addr    <= '0;
      snp_src     <= '0;
      sup_sel     <= '0;
      sup_idx     <= '0;
      sup_dirty_q <= 1'b0;
      wait_cnt    <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_shared  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (arb_any) begin
            grant     <= arb_oh;
            snp_valid <= 1'b1;
            snp_src   <= arb_idx;
            snp_inv   <= req_inv[arb_idx];
            snp_addr  <= req_addr[arb_idx*ADDR_W +: ADDR_W];
            state     <= ST_SNOOP;
          end
        end
        ST_SNOOP: begin
          snp_valid  <= 1'b0;
          rsp_shared <= pick_any;
          if (snp_inv) begin
            rsp_valid <= 1'b1;
            rsp_data  <= '0;
            state     <= ST_DONE;
          end else if (pick_any) begin
            sup_sel     <= pick_oh;
            sup_idx     <= pick_idx;
            sup_dirty_q <= snp_dirty[pick_idx];
            state       <= ST_SUPPLY;
          end else begin
            wait_cnt <= CNT_W'(MEM_LAT - 1);
            state    <= ST_MEMRD;
          end
        end
        ST_SUPPLY: begin
          sup_sel     <= '0;
          sup_dirty_q <= 1'b0;
          rsp_valid   <= 1'b1;
          rsp_data    <= sup_word;
          state       <= ST_DONE;
        end
        ST_MEMRD: begin
          if (wait_cnt == '0) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_q;
            state     <= ST_DONE;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        ST_DONE: begin
          rsp_valid <= 1'b0;
          grant     <= '0;
          rr_ptr    <= (snp_src == IDX_W'(N_CACHE - 1)) ? '0 : snp_src + 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !rsp_valid) |=> $stable(grant));

  // R3
  grant_release_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (grant != '0) ##1 (grant == '0));

  // R4
  snoop_owned_chk: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> grant[snp_src]);

  // R4
  snoop_single_chk: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> !snp_valid);

  // R6
  supplier_other_chk: assert property (@(posedge clk) disable iff (rst)
    (sup_sel != '0) |-> ($onehot(sup_sel) && ((sup_sel & grant) == '0)));

  // R6
  supply_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (sup_sel != '0) |=> (rsp_valid && sup_sel == '0));

  // R11
  inv_no_supply_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_inv && grant != '0) |-> (sup_sel == '0));
endmodule

// File: tb/snoop_bus_ctrl_test.sv
module snoop_bus_ctrl_test;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int LAT = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_inv = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N-1:0]    grant;
  logic            snp_valid, snp_inv;
  logic [AW-1:0]   snp_addr;
  logic [IW-1:0]   snp_src;
  logic [N-1:0]    snp_hit = '0;
  logic [N-1:0]    snp_dirty = '0;
  logic [N-1:0]    sup_sel;
  logic [N*DW-1:0] sup_data = '0;
  logic            rsp_valid;
  logic [DW-1:0]   rsp_data;
  logic            rsp_shared;

  always #2 clk = ~clk;

  snoop_bus_ctrl #(.N_CACHE(N), .ADDR_W(AW), .DATA_W(DW), .MEM_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_inv(req_inv), .req_addr(req_addr),
    .grant(grant), .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .snp_src(snp_src), .snp_hit(snp_hit), .snp_dirty(snp_dirty), .sup_sel(sup_sel),
    .sup_data(sup_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_shared(rsp_shared)
  );

  int checks = 0;
  int fails  = 0;
  int last_src = -1;
  bit done = 0;

  // transaction observations
  int r_gcyc, r_snpcyc, r_supcyc, r_rcyc;
  logic [N-1:0] r_sup;
  logic [DW-1:0] r_data;
  logic r_shared, r_snp_ok, r_hold_ok, r_drop_ok;

  function automatic logic [DW-1:0] init_word(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hA5A50000;
  endfunction

  function automatic logic [DW-1:0] lane_word(input int k, input int a);
    return 32'h5000_0000 + 32'(k) * 32'h0100_0000 + 32'(a);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_lanes(input int a);
    for (int k = 0; k < N; k++) sup_data[k*DW +: DW] = lane_word(k, a);
  endtask

  // one transaction from a single requester; results left in r_* variables
  task automatic run_txn(input int src, input bit inv, input int a,
                         input logic [N-1:0] hit, input logic [N-1:0] dirty);
    int cyc;
    @(negedge clk);
    snp_hit = hit; snp_dirty = dirty; set_lanes(a);
    req_addr[src*AW +: AW] = AW'(a);
    req_inv[src] = inv;
    req_valid[src] = 1'b1;
    r_gcyc = -1; r_snpcyc = -1; r_supcyc = -1; r_rcyc = -1; r_sup = '0;
    r_snp_ok = 1; r_hold_ok = 1; r_drop_ok = 1;
    cyc = 0;
    while (r_rcyc < 0 && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (grant != '0 && r_gcyc < 0) r_gcyc = cyc;
      if (r_gcyc >= 0 && grant != (N'(1) << src)) r_hold_ok = 0;
      if (snp_valid) begin
        if (r_snpcyc >= 0) r_snp_ok = 0;
        r_snpcyc = cyc;
        if (snp_addr != AW'(a) || snp_inv != inv || int'(snp_src) != src) r_snp_ok = 0;
      end
      if (sup_sel != '0) begin r_supcyc = cyc; r_sup = sup_sel; end
      if (rsp_valid) begin r_rcyc = cyc; r_data = rsp_data; r_shared = rsp_shared; end
    end
    req_valid[src] = 1'b0;
    @(negedge clk);
    if (grant != '0 || rsp_valid) r_drop_ok = 0;
    last_src = src;
  endtask

  task automatic t_reset();
    chk("R13 grant", grant, 0);
    chk("R13 sup_sel", sup_sel, 0);
    chk("R13 snp_valid", snp_valid, 0);
    chk("R13 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_mem_read(input int src, input int a, input logic [DW-1:0] exp, input string tag);
    run_txn(src, 0, a, '0, '0);
    chk({tag, " data"}, r_data, exp);
    chk("R5 latency", r_rcyc - r_gcyc, LAT + 1);
    chk("R2 grant one cycle after request", r_gcyc, 1);
    chk("R4 snoop in first grant cycle", r_snpcyc, r_gcyc);
    chk("R4 snoop fields/single", r_snp_ok, 1);
    chk("R1 R3 grant held one-hot", r_hold_ok, 1);
    chk("R3 grant dropped after rsp", r_drop_ok, 1);
    chk("R8 shared clear", r_shared, 0);
    chk("R6 no supplier", r_sup, 0);
  endtask

  task automatic t_own_hit();
    run_txn(2, 0, 9, 4'b0100, 4'b0100);
    chk("R7 own hit uses memory", r_data, init_word(9));
    chk("R7 own hit no supplier", r_sup, 0);
    chk("R7 R8 own hit not shared", r_shared, 0);
    chk("R7 memory latency", r_rcyc - r_gcyc, LAT + 1);
  endtask

  task automatic t_clean_share();
    run_txn(0, 0, 12, 4'b1011, 4'b0001);
    chk("R6 supplier lowest other", r_sup, 4'b0010);
    chk("R6 supply cycle after snoop", r_supcyc, r_snpcyc + 1);
    chk("R6 rsp after supply", r_rcyc, r_supcyc + 1);
    chk("R6 data from supplier lane", r_data, lane_word(1, 12));
    chk("R8 shared set", r_shared, 1);
    t_mem_read(3, 12, init_word(12), "R10 clean supply leaves memory");
  endtask

  task automatic t_dirty();
    run_txn(3, 0, 20, 4'b0110, 4'b0010);
    chk("R6 dirty supplier pick", r_sup, 4'b0010);
    chk("R6 dirty data", r_data, lane_word(1, 20));
    chk("R8 shared dirty", r_shared, 1);
    t_mem_read(0, 20, lane_word(1, 20), "R9 write-back visible");
  endtask

  task automatic t_inv();
    run_txn(1, 1, 7, 4'b0011, 4'b0001);
    chk("R11 inv no supplier", r_sup, 0);
    chk("R11 inv data zero", r_data, 0);
    chk("R11 inv rsp after snoop", r_rcyc, r_snpcyc + 1);
    chk("R8 inv shared", r_shared, 1);
    chk("R4 inv snoop fields", r_snp_ok, 1);
    run_txn(2, 1, 30, 4'b0100, 4'b0000);
    chk("R8 inv alone not shared", r_shared, 0);
    chk("R11 inv alone data zero", r_data, 0);
    t_mem_read(2, 7, init_word(7), "R11 inv leaves memory");
  endtask

  // three requesters at once; grant order follows rotating priority
  task automatic t_round_robin(input logic [N-1:0] set);
    logic [N-1:0] pend;
    int cyc;
    @(negedge clk);
    snp_hit = '0; snp_dirty = '0;
    pend = set;
    for (int k = 0; k < N; k++) begin
      req_inv[k] = 1'b0;
      req_addr[k*AW +: AW] = AW'(40 + k);
    end
    req_valid = set;
    while (pend != '0) begin
      int expw = -1;
      int got = -1;
      for (int k = N; k >= 1; k--) begin
        int j = (last_src + k) % N;
        if (pend[j]) expw = j;
      end
      cyc = 0;
      while (!rsp_valid && cyc < 60) begin @(negedge clk); cyc++; end
      for (int k = 0; k < N; k++) if (grant[k]) got = k;
      chk("R2 round-robin winner", got, expw);
      chk("R1 single grant", $countones(grant), 1);
      if (got >= 0) begin
        req_valid[got] = 1'b0;
        pend[got] = 1'b0;
        last_src = got;
      end else pend = '0;
      @(negedge clk);
      chk("R3 release between owners", grant, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_mem_read(1, 5, init_word(5), "R5 R12 memory read");
    t_own_hit();
    t_clean_share();
    t_dirty();
    t_inv();
    t_round_robin(4'b1101);
    t_round_robin(4'b0011);
    t_round_robin(4'b1110);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule